// File: doc/BRIEF.md
# Prescaled Trigger Delay One-Shot

This block sits between a timer and an ADC. When the timer reports its initial-value event or a compare-match event on `trig_in`, the block waits a programmable number of prescaled bus-clock ticks. It then issues a single-cycle hardware trigger towards the ADC. The tick rate comes from a free-running power-of-two prescaler. The same prescaler can also drive a divided clock onto an output pin, under its own enable.

Two small configuration fields are written through simple write strobes: the control field, which holds the prescaler select and the clock-output enable, and the 8-bit delay field. A control/status byte reads back the control field together with a read-only busy flag. No derived clock domain exists. Every flop runs on the bus clock, and the counter advances only on a one-cycle tick enable.

Top module: `trig_delay_oneshot`

## Requirements
- R1: After reset the delay field, the prescaler select and the clock-output enable are 0. `active`, `adc_trig` and `div_clk_out` are 0, and both read-back ports return 0.
- R2: `ctrl_rdata` carries the busy flag in bit 7, the clock-output enable in bit 3 and the prescaler select in bits 2..0, and bits 6..4 are always 0. A write with `ctrl_we` stores `ctrl_wdata[3]` as the enable and `ctrl_wdata[2:0]` as the select. A write with `delay_we` stores `delay_wdata`, and `delay_rdata` returns it.
- R3: The prescaler counter is 0 when reset is released and adds 1 on every bus clock. With select k, a tick occurs in each cycle whose counter has its low k bits all ones. Code 0 therefore ticks every cycle, and codes 1..7 tick once every 2, 4, 8, 16, 32, 64 or 128 cycles.
- R4: A `trig_in` that is high while the block is idle is accepted. `active` is 1 from the next cycle, the delay count restarts from 0, and a tick in the accepting cycle is not counted.
- R5: With delay value D (0..255), `active` falls at the (D+1)-th tick after the accepting cycle. With D = 0 it falls on the first tick.
- R6: A `trig_in` that arrives while `active` is 1 is ignored. It neither restarts the count nor adds a trigger.
- R7: `adc_trig` is exactly one bus clock wide. It is asserted in the cycle in which `active` has just fallen, and only if `hw_trig_en` was 1 on the final tick.
- R8: With `hw_trig_en` at 0, the delay still runs and `active` still falls on time, but no `adc_trig` is produced.
- R9: `div_clk_out` is 0 while the clock-output enable is 0. When the enable is 1 and the select is k ≥ 1, it equals bit k-1 of the prescaler counter, a square wave of period 2^k cycles. When the enable is 1 and the select is 0, it follows the bus clock.
- R10: While `active` is 1, the delay count changes only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Timer initial-value or compare-match event |
| hw_trig_en | input | 1 | Enables the ADC hardware trigger output |
| ctrl_we | input | 1 | Write strobe for the control field |
| ctrl_wdata | input | 4 | Bit 3 clock-output enable, bits 2..0 prescaler select |
| delay_we | input | 1 | Write strobe for the delay field |
| delay_wdata | input | 8 | New delay value |
| ctrl_rdata | output | 8 | Busy flag, zeros, enable and select read-back |
| delay_rdata | output | 8 | Delay field read-back |
| active | output | 1 | Delay counter running |
| adc_trig | output | 1 | One-cycle ADC hardware trigger |
| div_clk_out | output | 1 | Gated divided bus clock |

## Verification
The hardest situation to reach from the ports is a trigger that lands at a chosen phase of the free-running prescaler. Reaching it matters most for a retrigger that arrives while the count is between slow ticks. The bench tracks the prescaler phase by counting bus clocks from the release of reset. From that phase it predicts the cycle of every tick. It then places triggers, retriggers and hardware-enable changes at known phases under several select codes, including the slowest divide and the largest delay.

// File: rtl/tdly_pkg.sv
package tdly_pkg;
   localparam int SEL_W_DEF = 3;
   localparam int DLY_W_DEF = 8;
   localparam int RD_W      = 8;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;
endpackage

// File: rtl/tdly_regs.sv
module tdly_regs #(
   parameter int SEL_W = tdly_pkg::SEL_W_DEF,
   parameter int DLY_W = tdly_pkg::DLY_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [SEL_W:0]   ctrl_wdata,
   input  logic             delay_we,
   input  logic [DLY_W-1:0] delay_wdata,
   output logic [SEL_W-1:0] sel_q,
   output logic             clk_oe_q,
   output logic [DLY_W-1:0] delay_q
);
   localparam int OE_BIT = SEL_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         clk_oe_q <= 1'b0;
      end else if (ctrl_we) begin
         sel_q    <= ctrl_wdata[SEL_W-1:0];
         clk_oe_q <= ctrl_wdata[OE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        delay_q <= '0;
      else if (delay_we) delay_q <= delay_wdata;
   end

   // R2
   ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> (sel_q == $past(ctrl_wdata[SEL_W-1:0])));
endmodule

// File: rtl/tdly_prescaler.sv
module tdly_prescaler #(
   parameter int SEL_W = tdly_pkg::SEL_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             clk_oe,
   output logic             tick,
   output logic             div_clk_out
);
   localparam int NSEL  = 1 << SEL_W;
   localparam int PRE_W = NSEL - 1;

   logic [PRE_W-1:0] cnt;
   logic [NSEL-1:0]  tick_v;
   logic [NSEL-1:0]  div_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   for (genvar g = 0; g < NSEL; g++) begin : g_rate
      if (g == 0) begin : g_full
         assign tick_v[g] = 1'b1;
         assign div_v[g]  = clk;
      end else begin : g_div
         assign tick_v[g] = &cnt[g-1:0];
         assign div_v[g]  = cnt[g-1];
      end
   end

   assign tick        = tick_v[sel];
   assign div_clk_out = clk_oe & div_v[sel];

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) + 1'b1));
   // R9
   div_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_oe |-> !div_clk_out);
endmodule

// File: rtl/tdly_oneshot.sv
module tdly_oneshot #(
   parameter int DLY_W = tdly_pkg::DLY_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic             tick,
   input  logic [DLY_W-1:0] delay_q,
   input  logic             hw_en,
   output logic             active,
   output logic             adc_trig
);
   import tdly_pkg::*;

   run_state_e       state;
   logic [DLY_W-1:0] count;
   logic             done;

   assign done   = (state == ST_RUN) && tick && (count == delay_q);
   assign active = (state == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         count    <= '0;
         adc_trig <= 1'b0;
      end else begin
         adc_trig <= done && hw_en;
         case (state)
            ST_IDLE: if (trig_in) begin
               state <= ST_RUN;
               count <= '0;
            end
            ST_RUN: if (tick) begin
               if (count == delay_q) state <= ST_IDLE;
               else                  count <= count + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (count == '0));
   // R7
   pulse_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |-> (!active && $past(active)));
   // R7
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |=> !adc_trig);
   // R8
   hw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |-> $past(hw_en));
   // R6
   ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && trig_in && !tick) |=> active);
   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tick) |=> $stable(count));
endmodule

// File: rtl/trig_delay_oneshot.sv
module trig_delay_oneshot #(
   parameter int SEL_W = tdly_pkg::SEL_W_DEF,
   parameter int DLY_W = tdly_pkg::DLY_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic             hw_trig_en,
   input  logic             ctrl_we,
   input  logic [SEL_W:0]   ctrl_wdata,
   input  logic             delay_we,
   input  logic [DLY_W-1:0] delay_wdata,
   output logic [7:0]       ctrl_rdata,
   output logic [DLY_W-1:0] delay_rdata,
   output logic             active,
   output logic             adc_trig,
   output logic             div_clk_out
);
   localparam int BUSY_BIT = tdly_pkg::RD_W - 1;

   if (SEL_W < 1 || SEL_W + 1 > BUSY_BIT) begin : g_bad_sel
      $error("SEL_W must leave room below the busy bit");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("DLY_W must be at least 1");
   end

   logic [SEL_W-1:0] sel_q;
   logic             clk_oe_q;
   logic [DLY_W-1:0] delay_q;
   logic             tick;

   tdly_regs #(.SEL_W(SEL_W), .DLY_W(DLY_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .delay_we(delay_we), .delay_wdata(delay_wdata),
      .sel_q(sel_q), .clk_oe_q(clk_oe_q), .delay_q(delay_q)
   );

   tdly_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(sel_q), .clk_oe(clk_oe_q),
      .tick(tick), .div_clk_out(div_clk_out)
   );

   tdly_oneshot #(.DLY_W(DLY_W)) u_shot (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .tick(tick),
      .delay_q(delay_q), .hw_en(hw_trig_en),
      .active(active), .adc_trig(adc_trig)
   );

   always_comb begin
      ctrl_rdata              = '0;
      ctrl_rdata[BUSY_BIT]    = active;
      ctrl_rdata[SEL_W]       = clk_oe_q;
      ctrl_rdata[SEL_W-1:0]   = sel_q;
   end

   assign delay_rdata = delay_q;
endmodule

// File: tb/trig_delay_oneshot_test.sv
module trig_delay_oneshot_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig_in = 1'b0;
   logic       hw_trig_en = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [3:0] ctrl_wdata = '0;
   logic       delay_we = 1'b0;
   logic [7:0] delay_wdata = '0;
   logic [7:0] ctrl_rdata;
   logic [7:0] delay_rdata;
   logic       active;
   logic       adc_trig;
   logic       div_clk_out;

   int nchk = 0;
   int nfail = 0;
   int edge_n = 0;
   int exp_q[$];
   bit finished = 1'b0;

   always #10 clk = ~clk;

   trig_delay_oneshot uut (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .hw_trig_en(hw_trig_en),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .delay_we(delay_we), .delay_wdata(delay_wdata),
      .ctrl_rdata(ctrl_rdata), .delay_rdata(delay_rdata),
      .active(active), .adc_trig(adc_trig), .div_clk_out(div_clk_out)
   );

   always @(posedge clk) begin
      if (rst_n) edge_n <= edge_n + 1;
      else       edge_n <= 0;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops scoreboard entries as trigger pulses appear (R7)
   always @(negedge clk) begin
      if (rst_n && adc_trig) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected adc_trig", edge_n, -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            check(edge_n == e, "R5 adc_trig cycle", edge_n, e);
            check(active == 1'b0, "R7 active low with pulse", active, 0);
         end
      end
   end

   task automatic wr_ctrl(input logic [3:0] v);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_we = 1'b0;
   endtask

   task automatic wr_delay(input logic [7:0] v);
      @(negedge clk); delay_we = 1'b1; delay_wdata = v;
      @(negedge clk); delay_we = 1'b0;
   endtask

   // R3/R5 model: edge index after which active falls
   function automatic int final_tick(input int e, input int k, input int d);
      int mask = (1 << k) - 1;
      int m = e + 1;
      int ticks = 0;
      forever begin
         if ((m & mask) == mask) begin
            ticks++;
            if (ticks == d + 1) return m;
         end
         m++;
      end
   endfunction

   // driver: fires a trigger and pushes the expected pulse cycle
   task automatic fire(input int k, input int d, input bit expect_pulse, output int m);
      int e;
      @(negedge clk);
      e = edge_n;
      trig_in = 1'b1;
      m = final_tick(e, k, d);
      if (expect_pulse) exp_q.push_back(m + 1);
      @(negedge clk);
      trig_in = 1'b0;
      check(active == 1'b1, "R4 active after accept", active, 1);
   endtask

   task automatic wait_done();
      while (active || exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int m;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ctrl_rdata == 8'h00, "R1 ctrl_rdata", ctrl_rdata, 0);
      check(delay_rdata == 8'h00, "R1 delay_rdata", delay_rdata, 0);
      check(!active && !adc_trig && !div_clk_out, "R1 outputs", {active, adc_trig, div_clk_out}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ctrl_rdata == 8'h00, "R1 ctrl after release", ctrl_rdata, 0);

      // R2 layout
      wr_ctrl(4'hF);
      check(ctrl_rdata == 8'h0F, "R2 ctrl readback", ctrl_rdata, 8'h0F);
      wr_delay(8'hA5);
      check(delay_rdata == 8'hA5, "R2 delay readback", delay_rdata, 8'hA5);

      // R9 divided clock, select 3
      wr_ctrl(4'b1011);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         check(div_clk_out == ((edge_n >> 2) & 1), "R9 div select 3", div_clk_out, (edge_n >> 2) & 1);
      end
      wr_ctrl(4'b0011);
      repeat (4) begin
         @(negedge clk);
         check(div_clk_out == 1'b0, "R9 div disabled", div_clk_out, 0);
      end

      hw_trig_en = 1'b1;
      // R5 delay 0 at full rate
      wr_ctrl(4'b0000); wr_delay(8'd0);
      fire(0, 0, 1'b1, m); wait_done();
      // R5 delay 5 at full rate
      wr_delay(8'd5);
      fire(0, 5, 1'b1, m); wait_done();
      // R3 R10 select 3, delay 2
      wr_ctrl(4'b0011); wr_delay(8'd2);
      fire(3, 2, 1'b1, m); wait_done();
      // R3 slowest divide, delay 1
      wr_ctrl(4'b0111); wr_delay(8'd1);
      fire(7, 1, 1'b1, m); wait_done();
      // R5 largest delay at full rate
      wr_ctrl(4'b0000); wr_delay(8'd255);
      fire(0, 255, 1'b1, m); wait_done();

      // R6 retrigger while active
      wr_ctrl(4'b0010); wr_delay(8'd3);
      fire(2, 3, 1'b1, m);
      @(negedge clk); trig_in = 1'b1;
      @(negedge clk); trig_in = 1'b0;
      check(active == 1'b1, "R6 still active after retrigger", active, 1);
      wait_done();
      check(exp_q.size() == 0, "R6 single pulse", exp_q.size(), 0);

      // R8 hardware trigger disabled
      hw_trig_en = 1'b0;
      wr_ctrl(4'b0001); wr_delay(8'd2);
      fire(1, 2, 1'b0, m);
      while (edge_n < m) @(negedge clk);
      check(active == 1'b1, "R8 active before final tick", active, 1);
      @(negedge clk);
      check(active == 1'b0, "R8 active falls on time", active, 0);
      check(adc_trig == 1'b0, "R8 no pulse", adc_trig, 0);
      repeat (4) @(negedge clk);

      check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule